// File: doc/BRIEF.md
# Boot-time serial memory configuration loader

After the active-low reset is released, this block runs once and fetches one stored configuration set from an external serial EEPROM, acting as SPI master (mode 0). The set holds 19 bytes that are destined for the device registers at addresses 0x0A through 0x1C. A small select input picks which of up to eight slots in the memory is used. The slot start address is the slot number times a fixed stride: 19 bytes when packed, or 32 bytes when a parameter pads each slot to a power-of-two boundary.

The loader reads the whole set three times. Each read is one chip-select-low burst made of the read command, the start address and then the data bytes. The first two copies are kept. While the third copy arrives, each bit is settled by a 2-of-3 majority vote. Only after the third pass has finished are the voted bytes written to the register write port, one per cycle in ascending address order. A one-cycle done strobe then marks the end of the load, and a run level stays high until the next reset to allow normal operation.

Top module: `cfg_boot_loader`

## Requirements
- R1: While rst_ni is low, spi_cs_no is 1, spi_sck_o is 0, and reg_we_o, done_o and run_o are 0.
- R2: Each pass is a single burst with spi_cs_no held low throughout. SCK idles low and MISO is sampled on its rising edge. The burst carries, MSB first, the command byte 0x03, one address byte equal to the slot number times the stride (19 by default), and then clocks for exactly 19 data bytes.
- R3: Loading starts by itself after reset release, and exactly three passes are made, with spi_cs_no returning high between them.
- R4: Every bit of a committed byte equals the majority value of that bit across the three passes. A bit corrupted in only one pass is corrected. A bit flipped identically in two passes takes the flipped value.
- R5: No register write occurs until the third pass has ended. Then exactly 19 writes follow on consecutive cycles to addresses 0x0A, 0x0B, up to 0x1C, each carrying the voted byte for that offset.
- R6: done_o is high for exactly one cycle, in the cycle right after the write to 0x1C. run_o rises in that same cycle and stays high until reset.
- R7: cfg_sel_i is captured in the first cycle after reset release. Later changes to it do not alter the address sent or the data committed.
- R8: Once run_o is high, there is no further chip-select activity and no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; its release starts the load |
| cfg_sel_i | input | 3 | Configuration slot select |
| spi_sck_o | output | 1 | SPI serial clock, idle low |
| spi_cs_no | output | 1 | SPI chip select, active low |
| spi_mosi_o | output | 1 | SPI data to the memory |
| spi_miso_i | input | 1 | SPI data from the memory |
| reg_we_o | output | 1 | Register write strobe |
| reg_addr_o | output | 8 | Register write address |
| reg_wdata_o | output | 8 | Register write data |
| done_o | output | 1 | One-cycle end-of-load strobe |
| run_o | output | 1 | High once the configuration is committed |

## Verification
The assertions assume three things about the inputs:
- rst_ni is released once per load.
- cfg_sel_i is steady across that release.
- spi_miso_i changes only while SCK is low, as a mode-0 memory behaves.

The memory model in the bench updates MISO only on SCK falling edges and holds the select steady until several cycles after release. It corrupts a disjoint set of bits in each pass, so the vote always has two matching copies, except for one deliberate two-pass flip that checks the case where the majority itself is wrong.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam logic [7:0] CMD_READ = 8'h03;

  typedef enum logic [2:0] {
    S_BOOT, S_CSLOW, S_SEND, S_WAIT, S_GAP, S_COMMIT, S_RUN
  } ld_state_e;

  function automatic logic [7:0] maj3(input logic [7:0] a, input logic [7:0] b,
                                      input logic [7:0] c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/cfg_spi_byte.sv
module cfg_spi_byte #(
  parameter int DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic          active_q, phase_q, sck_q, done_q;
  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      sck_q    <= 1'b0;
      done_q   <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          tx_q     <= tx_i;
          bit_q    <= '0;
          phase_q  <= 1'b0;
          div_q    <= '0;
        end
      end else if (div_q == DW'(DIV - 1)) begin
        div_q <= '0;
        if (!phase_q) begin
          // rising edge: sample
          phase_q <= 1'b1;
          sck_q   <= 1'b1;
          rx_q    <= {rx_q[6:0], miso_i};
        end else begin
          // falling edge: advance
          phase_q <= 1'b0;
          sck_q   <= 1'b0;
          tx_q    <= {tx_q[6:0], 1'b0};
          if (bit_q == 3'd7) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
          end
        end
      end else begin
        div_q <= div_q + DW'(1);
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = tx_q[7];
  assign done_o = done_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/cfg_vote_store.sv
module cfg_vote_store #(
  parameter int NUM_BYTES = 19,
  parameter int IDX_W     = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       pass_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_o
);
  import cfg_loader_pkg::*;

  logic [7:0] first_q [NUM_BYTES];
  logic [7:0] second_q[NUM_BYTES];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    logic hit;
    assign hit = wr_i && (idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        first_q[g]  <= '0;
        second_q[g] <= '0;
      end else if (hit) begin
        case (pass_i)
          2'd0:    first_q[g]  <= data_i;
          2'd1:    second_q[g] <= data_i;
          default: first_q[g]  <= maj3(first_q[g], second_q[g], data_i);
        endcase
      end
    end
  end

  always_comb begin
    rd_o = '0;
    for (int k = 0; k < NUM_BYTES; k++)
      if (rd_idx_i == IDX_W'(k)) rd_o = first_q[k];
  end
endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader #(
  parameter int         NUM_SLOTS = 8,
  parameter int         NUM_BYTES = 19,
  parameter bit         PAD_SLOTS = 1'b0,
  parameter int         EE_ADDR_W = 8,
  parameter int         SCK_DIV   = 2,
  parameter logic [7:0] REG_BASE  = 8'h0A
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] cfg_sel_i,
  output logic       spi_sck_o,
  output logic       spi_cs_no,
  output logic       spi_mosi_o,
  input  logic       spi_miso_i,
  output logic       reg_we_o,
  output logic [7:0] reg_addr_o,
  output logic [7:0] reg_wdata_o,
  output logic       done_o,
  output logic       run_o
);
  import cfg_loader_pkg::*;

  localparam int SEL_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int STRIDE     = PAD_SLOTS ? (1 << $clog2(NUM_BYTES)) : NUM_BYTES;
  localparam int ADDR_BYTES = (EE_ADDR_W + 7) / 8;
  localparam int AW8        = ADDR_BYTES * 8;
  localparam int HDR        = 1 + ADDR_BYTES;
  localparam int FRAME      = HDR + NUM_BYTES;
  localparam int FW         = $clog2(FRAME + 1);
  localparam int IDX_W      = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

  ld_state_e        state_q;
  logic [1:0]       pass_q;
  logic [FW-1:0]    byte_q;
  logic [IDX_W-1:0] commit_q;
  logic [SEL_W-1:0] sel_q;
  logic             cs_n_q, done_q;

  logic             eng_start, eng_done;
  logic [7:0]       eng_tx, eng_rx;
  logic [AW8-1:0]   start_addr;
  logic             st_wr;
  logic [IDX_W-1:0] st_idx;
  logic [7:0]       voted;

  assign start_addr = AW8'(sel_q) * AW8'(STRIDE);
  assign eng_start  = (state_q == S_SEND);

  always_comb begin
    eng_tx = 8'h00;
    if (byte_q == '0) eng_tx = CMD_READ;
    for (int k = 1; k <= ADDR_BYTES; k++)
      if (byte_q == FW'(k)) eng_tx = start_addr[8*(ADDR_BYTES-k) +: 8];
  end

  assign st_wr  = (state_q == S_WAIT) && eng_done && (byte_q >= FW'(HDR));
  assign st_idx = IDX_W'(byte_q - FW'(HDR));

  cfg_spi_byte #(.DIV(SCK_DIV)) u_spi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(eng_start),
    .tx_i   (eng_tx),
    .miso_i (spi_miso_i),
    .sck_o  (spi_sck_o),
    .mosi_o (spi_mosi_o),
    .done_o (eng_done),
    .rx_o   (eng_rx)
  );

  cfg_vote_store #(.NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (st_wr),
    .pass_i  (pass_q),
    .idx_i   (st_idx),
    .data_i  (eng_rx),
    .rd_idx_i(commit_q),
    .rd_o    (voted)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_BOOT;
      pass_q   <= '0;
      byte_q   <= '0;
      commit_q <= '0;
      sel_q    <= '0;
      cs_n_q   <= 1'b1;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_BOOT: begin
          sel_q   <= SEL_W'(cfg_sel_i);
          state_q <= S_CSLOW;
        end
        S_CSLOW: begin
          cs_n_q  <= 1'b0;
          byte_q  <= '0;
          state_q <= S_SEND;
        end
        S_SEND: state_q <= S_WAIT;
        S_WAIT: if (eng_done) begin
          if (byte_q == FW'(FRAME - 1)) begin
            cs_n_q  <= 1'b1;
            state_q <= S_GAP;
          end else begin
            byte_q  <= byte_q + FW'(1);
            state_q <= S_SEND;
          end
        end
        S_GAP: begin
          if (pass_q == 2'd2) begin
            commit_q <= '0;
            state_q  <= S_COMMIT;
          end else begin
            pass_q  <= pass_q + 2'd1;
            state_q <= S_CSLOW;
          end
        end
        S_COMMIT: begin
          if (commit_q == IDX_W'(NUM_BYTES - 1)) begin
            done_q  <= 1'b1;
            state_q <= S_RUN;
          end else begin
            commit_q <= commit_q + IDX_W'(1);
          end
        end
        S_RUN: state_q <= S_RUN;
        default: state_q <= S_BOOT;
      endcase
    end
  end

  assign spi_cs_no   = cs_n_q;
  assign reg_we_o    = (state_q == S_COMMIT);
  assign reg_addr_o  = REG_BASE + 8'(commit_q);
  assign reg_wdata_o = voted;
  assign done_o      = done_q;
  assign run_o       = (state_q == S_RUN);
endmodule

// File: rtl/cfg_boot_loader_chk.sv
module cfg_boot_loader_chk #(
  parameter int         NUM_BYTES = 19,
  parameter logic [7:0] REG_BASE  = 8'h0A
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] cfg_sel_i,
  input logic       spi_sck_o,
  input logic       spi_cs_no,
  input logic       spi_mosi_o,
  input logic       spi_miso_i,
  input logic       reg_we_o,
  input logic [7:0] reg_addr_o,
  input logic [7:0] reg_wdata_o,
  input logic       done_o,
  input logic       run_o
);
  localparam logic [7:0] LAST_ADDR = REG_BASE + 8'(NUM_BYTES - 1);

  logic       cs_prev_q;
  logic [1:0] falls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_prev_q <= 1'b1;
      falls_q   <= '0;
    end else begin
      cs_prev_q <= spi_cs_no;
      if (cs_prev_q && !spi_cs_no && falls_q != 2'd3) falls_q <= falls_q + 2'd1;
    end
  end

  p_sck_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o);
  p_mosi_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_sck_o && $past(spi_sck_o)) |-> $stable(spi_mosi_o));
  p_no_fourth_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(falls_q == 2'd3 && cs_prev_q && !spi_cs_no));
  p_write_after_passes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (spi_cs_no && falls_q == 2'd3));
  p_addr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && $past(reg_we_o)) |-> reg_addr_o == $past(reg_addr_o) + 8'd1);
  p_first_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_we_o) |-> reg_addr_o == REG_BASE);
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(reg_we_o) && $past(reg_addr_o) == LAST_ADDR && run_o));
  p_run_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |=> run_o);
  p_quiet_after_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> (spi_cs_no && !reg_we_o));
endmodule

bind cfg_boot_loader cfg_boot_loader_chk #(
  .NUM_BYTES(NUM_BYTES), .REG_BASE(REG_BASE)
) u_chk (.*);

// File: tb/cfg_boot_loader_tb_top.sv
module cfg_boot_loader_tb_top;
  localparam int NB = 19;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic       sck, cs_n, mosi, miso = 1'b0;
  logic       we, done, run;
  logic [7:0] waddr, wdata;

  always #10 clk = ~clk;

  cfg_boot_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_sel_i(cfg_sel),
    .spi_sck_o(sck), .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso),
    .reg_we_o(we), .reg_addr_o(waddr), .reg_wdata_o(wdata),
    .done_o(done), .run_o(run)
  );

  int  n_checks = 0, n_fail = 0;
  bit  finished = 0;
  int  cur_mode = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_val(input logic [7:0] a);
    return 8'(a * 8'd37 + 8'd5) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
    return 8'((v << (n % 8)) | (v >> ((8 - n % 8) % 8)));
  endfunction

  // Per-pass corruption: disjoint bits per pass, plus a two-pass flip in mode 2
  function automatic logic [7:0] corrupt(input int p, input int i, input int mode);
    logic [7:0] m;
    m = '0;
    if (mode >= 1) m = rotl(8'h03 << (2 * p), i);
    if (mode == 2 && i == 0 && p < 2) m = m | 8'h80;
    return m;
  endfunction

  // ---------------- serial memory model ----------------
  int         ee_falls = 0, ee_rise = 0;
  logic [15:0] hdr_sh = '0;
  logic [7:0] log_cmd[3], log_addr[3];
  int         log_bytes[3];

  always @(negedge cs_n) begin
    ee_rise = 0;
    ee_falls++;
  end

  always @(posedge cs_n) begin
    if (ee_falls >= 1 && ee_falls <= 3)
      log_bytes[ee_falls-1] = (ee_rise - 16) / 8;
  end

  always @(posedge sck) begin
    if (!cs_n) begin
      if (ee_rise < 16) hdr_sh = {hdr_sh[14:0], mosi};
      ee_rise++;
      if (ee_rise == 16 && ee_falls >= 1 && ee_falls <= 3) begin
        log_cmd[ee_falls-1]  = hdr_sh[15:8];
        log_addr[ee_falls-1] = hdr_sh[7:0];
      end
    end
  end

  always @(negedge sck) begin
    if (!cs_n && ee_rise >= 16 && ee_falls >= 1 && ee_falls <= 3) begin
      int idx;
      logic [7:0] b;
      idx = ee_rise - 16;
      b = mem_val(8'(log_addr[ee_falls-1] + 8'(idx / 8))) ^
          corrupt(ee_falls - 1, idx / 8, cur_mode);
      miso = b[7 - idx % 8];
    end
  end

  // ---------------- scoreboard ----------------
  logic [15:0] exp_q[$];
  int  n_writes = 0, n_done = 0, falls_at_first = 0;
  bit  prev_done = 0, prev_we = 0;
  logic [7:0] prev_addr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (we) begin
        if (n_writes == 0) falls_at_first = ee_falls;
        n_writes++;
        if (exp_q.size() == 0) begin
          check(0, "R5", "unexpected write", int'({waddr, wdata}), 0);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(waddr == e[15:8], "R5", "write address", waddr, e[15:8]);
          check(wdata == e[7:0], "R4", "voted data", wdata, e[7:0]);
        end
      end
      if (done) begin
        n_done++;
        check(prev_we && prev_addr == 8'h1C, "R6", "done after last write",
              int'(prev_addr), 8'h1C);
      end
      if (prev_done) check(!done, "R6", "done width", done, 0);
      prev_done = done;
      prev_we   = we;
      prev_addr = waddr;
    end
  end

  task automatic push_expected(input int sel, input int mode);
    for (int i = 0; i < NB; i++) begin
      logic [7:0] v0, v1, v2, base;
      base = 8'(sel * NB + i);
      v0 = mem_val(base) ^ corrupt(0, i, mode);
      v1 = mem_val(base) ^ corrupt(1, i, mode);
      v2 = mem_val(base) ^ corrupt(2, i, mode);
      exp_q.push_back({8'(8'h0A + i), (v0 & v1) | (v0 & v2) | (v1 & v2)});
    end
  endtask

  task automatic run_case(input int sel, input int mode, input bit move_sel);
    int waited;
    int falls_done, writes_done;
    rst_n = 1'b0;
    @(negedge clk);
    cur_mode = mode;
    cfg_sel  = 3'(sel);
    ee_falls = 0;
    n_writes = 0;
    n_done   = 0;
    prev_done = 0;
    prev_we   = 0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    check(cs_n && !sck && !we && !done && !run, "R1", "reset outputs",
          int'({cs_n, sck, we, done, run}), 5'b10000);
    push_expected(sel, mode);
    rst_n = 1'b1;
    if (move_sel) begin
      repeat (10) @(negedge clk);
      cfg_sel = 3'(sel ^ 7);
    end
    waited = 0;
    while (n_done == 0 && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    check(n_done == 1, "R6", "done seen", n_done, 1);
    check(run, "R6", "run high after done", run, 1);
    check(ee_falls == 3, "R3", "pass count", ee_falls, 3);
    check(falls_at_first == 3 && n_writes == NB, "R5", "writes after third pass",
          falls_at_first, 3);
    for (int p = 0; p < 3; p++) begin
      check(log_cmd[p] == 8'h03, "R2", "read command", log_cmd[p], 8'h03);
      check(log_addr[p] == 8'(sel * NB), move_sel ? "R7" : "R2", "start address",
            log_addr[p], 8'(sel * NB));
      check(log_bytes[p] == NB, "R2", "burst length", log_bytes[p], NB);
    end
    falls_done  = ee_falls;
    writes_done = n_writes;
    repeat (200) @(negedge clk);
    check(ee_falls == falls_done && n_writes == writes_done && cs_n, "R8",
          "quiet after run", ee_falls, falls_done);
    check(run && n_done == 1, "R6", "run held", run, 1);
    check(exp_q.size() == 0, "R5", "all expected writes seen", exp_q.size(), 0);
  endtask

  initial begin
    run_case(0, 0, 0);  // clean data, first slot
    run_case(7, 1, 0);  // last slot, single-pass faults
    run_case(3, 2, 1);  // two-pass flip on byte 0 bit 7, select moved mid-load
    run_case(5, 1, 0);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule